// File: doc/BRIEF.md
# Event Log Ring Writer with Overflow Recovery

This block takes fixed-width event records from on-chip sources and stores them in a circular buffer that software empties. Hardware owns the tail pointer. Software owns the head pointer and moves it forward with a register write once it has consumed entries through the buffer read port. One slot always stays empty, so the block can tell a full ring from an empty one.

If a record arrives while logging is active and the ring has no free slot, the block drops that record. It then sets a sticky overflow flag and stops logging. Logging stays stopped even after space frees up. To restart, software first clears the flag by writing 1 to it. It then writes the log-enable control bit to 0 and afterwards to 1. Only that 0-to-1 transition restarts logging. A repeated write of 1 has no effect, and so does a 0-to-1 transition made while the flag is still set.

The record input always completes its handshake in one cycle, whether the record is stored or dropped. A small register window holds control, status, head and tail. An interrupt output reports the status bits when interrupts are enabled.

Top module: `evlog_ring`

## Requirements
- R1: After reset, control, status, head and tail all read 0, and `irq` is 0.
- R2: A valid record that arrives with log enable (control bit 0) at 1, logging active and a free slot is written to the slot at the tail. The tail then moves forward by 1, wrapping modulo DEPTH, and status bit 1 (logged) is set. Software reads back the stored records in arrival order.
- R3: The ring is full when the tail plus 1 (modulo DEPTH) equals the head. A record that arrives while the ring is full and logging is active is dropped. In that case the tail and the stored contents do not change, and status bit 0 (overflow) is set.
- R4: Both status bits are cleared by writing 1 to them at address 1. Writing 0 to a status bit leaves it unchanged. If a hardware set and a software clear of the same bit fall in the same cycle, the set wins.
- R5: `irq` is 1 exactly when control bit 1 (interrupt enable) is 1 and at least one of the overflow or logged status bits is 1.
- R6: While the overflow bit is 1, no record is stored, even when the ring has free slots.
- R7: Logging resumes after an overflow only when software writes control bit 0 from 0 to 1 while the overflow bit is already 0. A repeated write of 1 does not resume logging. A 0-to-1 transition made while the overflow bit is still 1 does not resume logging either.
- R8: While log enable is 0, incoming records are dropped without changing the tail and without setting the overflow bit.
- R9: A write to the head register (address 2) keeps only the low log2(DEPTH) bits. The tail register (address 3) is read-only, and writes to it are ignored.
- R10: `ev_ready` is always 1 once reset is released, so every offered record is consumed in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event record offered |
| ev_ready | output | 1 | Record consumed this cycle |
| ev_rec | input | REC_W | Opaque event record |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 head, 3 tail |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for the selected address (combinational) |
| buf_raddr | input | log2(DEPTH) | Software read index into the ring |
| buf_rdata | output | REC_W | Ring contents at `buf_raddr` |
| irq | output | 1 | Interrupt request |

## Verification
A wrong freeze or full decision shows up on the first record after the fault. The tail read at address 3 either moves when it should hold or holds when it should move, one cycle after the record is offered. A corrupted write index or wrong write data is not visible in the tail. It appears only when software drains the ring and the scoreboard finds a record out of order or altered. A stuck or badly prioritised status bit shows up on `irq` and at address 1 in the cycle after the write or event that should have changed it.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_HEAD = 2'd2;
   localparam logic [1:0] ADDR_TAIL = 2'd3;

   localparam int CTRL_LOG_EN = 0;
   localparam int CTRL_IRQ_EN = 1;
   localparam int ST_OVF      = 0;
   localparam int ST_LOGGED   = 1;

   typedef enum logic [1:0] {
      FATE_IDLE  = 2'd0,
      FATE_STORE = 2'd1,
      FATE_OVF   = 2'd2,
      FATE_QUIET = 2'd3
   } ev_fate_e;
endpackage

// File: rtl/evlog_mem.sv
module evlog_mem #(
   parameter int REC_W  = 32,
   parameter int DEPTH  = 16,
   parameter bit RD_REG = 1'b0,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [REC_W-1:0] wdata,
   input  logic [IDX_W-1:0] raddr,
   output logic [REC_W-1:0] rdata
);
   logic [REC_W-1:0] slots [DEPTH];

   always_ff @(posedge clk) begin
      if (we) slots[waddr] <= wdata;
   end

   generate
      if (RD_REG) begin : g_rd_reg
         logic [REC_W-1:0] rd_q;
         always_ff @(posedge clk) rd_q <= slots[raddr];
         assign rdata = rd_q;
      end else begin : g_rd_comb
         assign rdata = slots[raddr];
      end
   endgenerate
endmodule

// File: rtl/evlog_ptr.sv
module evlog_ptr #(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic             head_we,
   input  logic [IDX_W-1:0] head_wdata,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail,
   output logic             full
);
   localparam logic [IDX_W-1:0] STEP = IDX_W'(1);

   logic [IDX_W-1:0] head_q, tail_q, tail_nx;

   assign tail_nx = tail_q + STEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         if (advance) tail_q <= tail_nx;
         if (head_we) head_q <= head_wdata;
      end
   end

   assign head = head_q;
   assign tail = tail_q;
   assign full = (tail_nx == head_q);

   // R2: each store moves the tail by exactly one, with wrap
   a_r2_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> tail_q == $past(tail_q) + STEP);
   // R3: the controller never stores into a full ring
   a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !advance);
endmodule

// File: rtl/evlog_ctrl.sv
module evlog_ctrl
   import evlog_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_we,
   input  logic [1:0] reg_addr,
   input  logic [1:0] reg_wbits,
   input  logic       ev_valid,
   input  logic       full,
   output logic       store,
   output logic       log_en,
   output logic       irq_en,
   output logic       ovf,
   output logic       logged,
   output logic       irq
);
   logic     log_en_q, irq_en_q, ovf_q, logged_q, frozen_q;
   logic     ctrl_wr, stat_wr, rearm, active;
   ev_fate_e fate;

   assign ctrl_wr = reg_we && (reg_addr == ADDR_CTRL);
   assign stat_wr = reg_we && (reg_addr == ADDR_STAT);
   assign rearm   = ctrl_wr && reg_wbits[CTRL_LOG_EN] && !log_en_q && !ovf_q;
   assign active  = log_en_q && !frozen_q && !ovf_q;

   always_comb begin
      if (!ev_valid)    fate = FATE_IDLE;
      else if (!active) fate = FATE_QUIET;
      else if (full)    fate = FATE_OVF;
      else              fate = FATE_STORE;
   end

   assign store = (fate == FATE_STORE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         log_en_q <= 1'b0;
         irq_en_q <= 1'b0;
         ovf_q    <= 1'b0;
         logged_q <= 1'b0;
         frozen_q <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            log_en_q <= reg_wbits[CTRL_LOG_EN];
            irq_en_q <= reg_wbits[CTRL_IRQ_EN];
         end
         if (fate == FATE_OVF)                     ovf_q <= 1'b1;
         else if (stat_wr && reg_wbits[ST_OVF])    ovf_q <= 1'b0;
         if (fate == FATE_STORE)                   logged_q <= 1'b1;
         else if (stat_wr && reg_wbits[ST_LOGGED]) logged_q <= 1'b0;
         if (fate == FATE_OVF)                     frozen_q <= 1'b1;
         else if (rearm)                           frozen_q <= 1'b0;
      end
   end

   assign log_en = log_en_q;
   assign irq_en = irq_en_q;
   assign ovf    = ovf_q;
   assign logged = logged_q;
   assign irq    = irq_en_q && (ovf_q || logged_q);

   // R4: overflow flag stays set unless software writes 1 to it
   a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !(stat_wr && reg_wbits[ST_OVF])) |=> ovf_q);
   // R7: leaving the frozen state needs log enable now 1 and overflow clear
   a_r7_unfreeze_cond: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frozen_q) |-> (log_en_q && !ovf_q && !$past(log_en_q)));
endmodule

// File: rtl/evlog_ring.sv
module evlog_ring
   import evlog_pkg::*;
#(
   parameter int REC_W  = 32,
   parameter int DEPTH  = 16,
   parameter int DW     = 32,
   parameter bit RD_REG = 1'b0,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_valid,
   output logic             ev_ready,
   input  logic [REC_W-1:0] ev_rec,
   input  logic             reg_we,
   input  logic [1:0]       reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   input  logic [IDX_W-1:0] buf_raddr,
   output logic [REC_W-1:0] buf_rdata,
   output logic             irq
);
   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("evlog_ring: DEPTH must be a power of two of at least 4");
      end
      if (DW < IDX_W || DW < 2) begin : g_bad_dw
         $error("evlog_ring: DW too narrow for the pointer registers");
      end
   endgenerate

   logic             store, full, log_en, irq_en, ovf, logged, head_we;
   logic [IDX_W-1:0] head, tail;
   logic             unused_wbits;

   assign unused_wbits = ^reg_wdata;
   assign head_we      = reg_we && (reg_addr == ADDR_HEAD);
   assign ev_ready     = rst_n;

   evlog_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_we   (reg_we),
      .reg_addr (reg_addr),
      .reg_wbits(reg_wdata[1:0]),
      .ev_valid (ev_valid),
      .full     (full),
      .store    (store),
      .log_en   (log_en),
      .irq_en   (irq_en),
      .ovf      (ovf),
      .logged   (logged),
      .irq      (irq)
   );

   evlog_ptr #(.IDX_W(IDX_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (store),
      .head_we   (head_we),
      .head_wdata(reg_wdata[IDX_W-1:0]),
      .head      (head),
      .tail      (tail),
      .full      (full)
   );

   evlog_mem #(.REC_W(REC_W), .DEPTH(DEPTH), .RD_REG(RD_REG)) u_mem (
      .clk  (clk),
      .we   (store),
      .waddr(tail),
      .wdata(ev_rec),
      .raddr(buf_raddr),
      .rdata(buf_rdata)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_CTRL: begin
            reg_rdata[CTRL_LOG_EN] = log_en;
            reg_rdata[CTRL_IRQ_EN] = irq_en;
         end
         ADDR_STAT: begin
            reg_rdata[ST_OVF]    = ovf;
            reg_rdata[ST_LOGGED] = logged;
         end
         ADDR_HEAD: reg_rdata = DW'(head);
         default:   reg_rdata = DW'(tail);
      endcase
   end

   // R6: the tail holds for as long as the overflow flag is up
   a_r6_frozen_tail: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> $stable(tail));
   // R8: with logging off and no overflow pending, no overflow can appear
   a_r8_quiet_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (!log_en && !ovf) |=> !ovf);
   // R5: interrupt pin matches the enable and the status bits
   a_r5_irq_pin: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_en && (ovf || logged)));
endmodule

// File: tb/evlog_ring_test.sv
module evlog_ring_test;
   localparam int REC_W = 32;
   localparam int DEPTH = 16;
   localparam int DW    = 32;
   localparam int IDX_W = $clog2(DEPTH);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ev_valid = 1'b0;
   logic             ev_ready;
   logic [REC_W-1:0] ev_rec = '0;
   logic             reg_we = 1'b0;
   logic [1:0]       reg_addr = 2'd0;
   logic [DW-1:0]    reg_wdata = '0;
   logic [DW-1:0]    reg_rdata;
   logic [IDX_W-1:0] buf_raddr = '0;
   logic [REC_W-1:0] buf_rdata;
   logic             irq;

   int vectors = 0;
   int errors  = 0;
   logic [REC_W-1:0] sb_q [$];
   int exp_tail = 0;
   int exp_head = 0;
   int seq = 0;

   always #2 clk = ~clk;

   evlog_ring #(.REC_W(REC_W), .DEPTH(DEPTH), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
      .ev_rec(ev_rec), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_raddr(buf_raddr),
      .buf_rdata(buf_rdata), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // driver: offer one record, push it to the scoreboard when it must be stored
   task automatic send(input bit expect_store);
      @(negedge clk);
      ev_valid = 1'b1;
      ev_rec = 32'hE000_0000 + 32'(seq);
      if (expect_store) begin
         sb_q.push_back(ev_rec);
         exp_tail = (exp_tail + 1) % DEPTH;
      end
      seq++;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   // monitor: drain the ring as software would and compare with the scoreboard
   task automatic drain();
      logic [DW-1:0] t;
      rd(2'd3, t);
      while (exp_head != int'(t)) begin
         logic [REC_W-1:0] want;
         @(negedge clk);
         buf_raddr = IDX_W'(exp_head);
         #1;
         want = (sb_q.size() > 0) ? sb_q.pop_front() : 32'hDEAD_BEEF;
         check("R2 drained record", buf_rdata, want);
         exp_head = (exp_head + 1) % DEPTH;
      end
      check("R2 scoreboard empty after drain", 32'(sb_q.size()), 32'd0);
      wr(2'd2, DW'(exp_head));
   endtask

   task automatic chk_reg(input string tag, input logic [1:0] a, input logic [31:0] exp);
      logic [DW-1:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, R10 ready
      chk_reg("R1 ctrl", 2'd0, 0);
      chk_reg("R1 status", 2'd1, 0);
      chk_reg("R1 head", 2'd2, 0);
      chk_reg("R1 tail", 2'd3, 0);
      check("R1 irq", 32'(irq), 0);
      check("R10 ready", 32'(ev_ready), 1);

      // R8: logging off drops silently
      send(1'b0);
      chk_reg("R8 tail unchanged", 2'd3, 0);
      chk_reg("R8 no overflow", 2'd1, 0);

      // R2 basic store
      wr(2'd0, 32'h1);
      for (int i = 0; i < 3; i++) send(1'b1);
      chk_reg("R2 tail after 3", 2'd3, 32'(exp_tail));
      chk_reg("R2 logged bit", 2'd1, 32'h2);
      check("R5 irq off while disabled", 32'(irq), 0);
      wr(2'd0, 32'h3);
      check("R5 irq on logged", 32'(irq), 1);
      wr(2'd1, 32'h0);
      chk_reg("R4 write 0 keeps", 2'd1, 32'h2);
      wr(2'd1, 32'h2);
      chk_reg("R4 w1c logged", 2'd1, 32'h0);
      check("R5 irq off after clear", 32'(irq), 0);
      drain();

      // R9 head masking, tail read-only
      wr(2'd2, 32'hFFFF_FFF0 | 32'(exp_head));
      chk_reg("R9 head masked", 2'd2, 32'(exp_head));
      wr(2'd3, 32'h5);
      chk_reg("R9 tail read-only", 2'd3, 32'(exp_tail));

      // R2 wrap, R3 overflow
      for (int i = 0; i < DEPTH - 1; i++) send(1'b1);
      chk_reg("R2 tail wrapped", 2'd3, 32'(exp_tail));
      chk_reg("R3 not yet overflow", 2'd1, 32'h2);
      send(1'b0);
      chk_reg("R3 tail held on full", 2'd3, 32'(exp_tail));
      chk_reg("R3 overflow set", 2'd1, 32'h3);
      check("R5 irq on overflow", 32'(irq), 1);
      drain();
      send(1'b0);
      chk_reg("R6 frozen with space", 2'd3, 32'(exp_tail));

      // R7: repeated 1 does not resume
      wr(2'd1, 32'h3);
      chk_reg("R4 w1c both", 2'd1, 32'h0);
      wr(2'd0, 32'h3);
      send(1'b0);
      chk_reg("R7 repeated enable ignored", 2'd3, 32'(exp_tail));
      wr(2'd0, 32'h2);
      wr(2'd0, 32'h3);
      // R4 priority: store and clear of logged in the same cycle
      @(negedge clk);
      ev_valid = 1'b1; ev_rec = 32'hC0DE_0001;
      reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h2;
      sb_q.push_back(ev_rec);
      exp_tail = (exp_tail + 1) % DEPTH;
      @(negedge clk);
      ev_valid = 1'b0; reg_we = 1'b0;
      chk_reg("R7 resumed after 0-1", 2'd3, 32'(exp_tail));
      chk_reg("R4 set beats clear", 2'd1, 32'h2);
      drain();

      // R8 again with data in flight
      wr(2'd0, 32'h2);
      send(1'b0);
      chk_reg("R8 tail unchanged", 2'd3, 32'(exp_tail));

      // R7: re-arm while overflow still set is refused
      wr(2'd0, 32'h3);
      for (int i = 0; i < DEPTH - 1; i++) send(1'b1);
      send(1'b0);
      chk_reg("R3 overflow again", 2'd1, 32'h3);
      wr(2'd0, 32'h2);
      wr(2'd0, 32'h3);
      wr(2'd1, 32'h1);
      drain();
      send(1'b0);
      chk_reg("R7 early re-arm ignored", 2'd3, 32'(exp_tail));
      wr(2'd0, 32'h2);
      wr(2'd0, 32'h3);
      send(1'b1);
      chk_reg("R7 proper re-arm", 2'd3, 32'(exp_tail));
      drain();
      check("R10 ready at end", 32'(ev_ready), 1);

      summary();
      $finish;
   end
endmodule